// File: doc/BRIEF.md
# I/O Port Decoder with Fast Register Window

This block sits on the data side of a small 16-bit processor and decodes its 32-bit byte address space for loads and stores. Four bytes at the top of the address space (0xFFFF0000 to 0xFFFF0003) are fixed I/O ports. Two write-only latches drive the pins of a character LCD, and one read-only location returns the setting of a 4-bit DIP switch. A 32-byte window at 0xFFFF1000 to 0xFFFF101F maps sixteen 16-bit fast registers. The processor can also read and write those registers by a 4-bit index through a separate port, in the same cycle as a memory access. Every other address passes through to an external RAM.

Two fast registers have a fixed role. Slot 0 is the page register, which supplies the upper half of register-indirect addresses. Slot 15 holds the stack pointer, and the processor can load it directly over a side channel. All memory-port reads return data one cycle after the request, whether they hit a port, the fast window or RAM. Word accesses follow little-endian byte order, and byte lanes are swapped on odd addresses.

Top module: `ioport_fastmem`

## Requirements
- R1: After reset, all sixteen fast slots, both LCD latches and `cpu_rdata` are 0. In any cycle that follows a cycle with no read request, `cpu_rdata` is 0.
- R2: A write (`cpu_en`=1, `cpu_we`=1) to 0xFFFF0000 loads `cpu_wdata[7:0]` into `lcd_data` on the next clock edge. A write to 0xFFFF0001 loads it into `lcd_ctrl` instead. The value of `cpu_byte` does not matter for these writes.
- R3: A read (`cpu_en`=1, `cpu_we`=0) of 0xFFFF0002 returns `{12'h0, dip_sw}` on `cpu_rdata` in the following cycle.
- R4: A read of 0xFFFF0000, 0xFFFF0001 or 0xFFFF0003 returns 0. A write to 0xFFFF0002 or 0xFFFF0003 changes neither LCD latch nor any fast slot.
- R5: An address in 0xFFFF1000..0xFFFF101F selects fast slot `addr[4:1]`. A word access (`cpu_byte`=0) at an even address writes or returns the slot value unchanged.
- R6: A word read at an odd fast address returns the slot with its two bytes swapped. A word write at an odd fast address stores `{wdata[7:0], wdata[15:8]}`.
- R7: A byte access (`cpu_byte`=1) with `addr[0]`=0 uses bits 7:0 of the slot, and with `addr[0]`=1 uses bits 15:8. A byte write takes `cpu_wdata[7:0]` and leaves the other byte unchanged. A byte read returns the byte zero-extended.
- R8: `fx_rdata` shows slot `fx_idx` combinationally. `fx_we` writes `fx_wdata` into that slot on the next edge. When both the index port and the memory port write the same slot in one cycle, the index port's value is stored.
- R9: `page_q` always shows slot 0 and `sp_q` always shows slot 15. `sp_ld` loads `sp_ld_val` into slot 15, and it takes priority over both other write paths.
- R10: For any other address, `ram_en` follows `cpu_en`, `ram_we` follows `cpu_we`, and address, data and byte size pass through in the same cycle. For a port or fast address, `ram_en` and `ram_we` stay 0. After a RAM read, `cpu_rdata` carries `ram_rdata` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_en | input | 1 | Memory request valid |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_byte | input | 1 | 1 = byte access, 0 = 16-bit word |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 16 | Store data |
| cpu_rdata | output | 16 | Load data, one cycle after the request |
| fx_idx | input | 4 | Fast register index |
| fx_we | input | 1 | Index-port write strobe |
| fx_wdata | input | 16 | Index-port write data |
| fx_rdata | output | 16 | Slot selected by `fx_idx` |
| sp_ld | input | 1 | Load the stack pointer slot |
| sp_ld_val | input | 16 | New stack pointer value |
| sp_q | output | 16 | Current stack pointer (slot 15) |
| page_q | output | 16 | Current page register (slot 0) |
| dip_sw | input | 4 | DIP switch setting |
| lcd_data | output | 8 | LCD data pins |
| lcd_ctrl | output | 8 | LCD control pins |
| ram_en | output | 1 | RAM request |
| ram_we | output | 1 | RAM write |
| ram_byte | output | 1 | RAM byte-size access |
| ram_addr | output | 32 | RAM byte address |
| ram_wdata | output | 16 | RAM write data |
| ram_rdata | input | 16 | RAM read data, valid one cycle after a RAM read |

## Verification
The bench drives directed cases and then a long random stream, and a behavioural model follows the block on every cycle.

- **Byte order.** The bench writes and reads odd fast addresses in both word and byte sizes. A design that forgets the swap, or picks the wrong lane, returns the bytes in the wrong order or corrupts the neighbouring byte.
- **Write collisions.** The bench writes one slot from the memory port, the index port and the stack-pointer load in the same cycle. A wrong priority leaves the losing value in the slot, where `fx_rdata` or `sp_q` shows it.
- **Port decode.** It stores to the switch address and loads from the LCD addresses. A decoder that is too loose latches LCD data from the wrong address, or returns stale latch contents.
- **Read timing.** RAM reads are interleaved with local reads. A design with the wrong read timing returns one request's data in the cycle of another.

// File: rtl/ioport_fastmem.sv
module ioport_fastmem #(
  parameter int AW = 32,
  parameter int DW = 16,
  parameter int NSLOT = 16,
  parameter logic [31:0] PORT_BASE = 32'hFFFF0000,
  parameter logic [31:0] FAST_BASE = 32'hFFFF1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_en,
  input  logic          cpu_we,
  input  logic          cpu_byte,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  input  logic [3:0]    fx_idx,
  input  logic          fx_we,
  input  logic [DW-1:0] fx_wdata,
  output logic [DW-1:0] fx_rdata,
  input  logic          sp_ld,
  input  logic [DW-1:0] sp_ld_val,
  output logic [DW-1:0] sp_q,
  output logic [DW-1:0] page_q,
  input  logic [3:0]    dip_sw,
  output logic [7:0]    lcd_data,
  output logic [7:0]    lcd_ctrl,
  output logic          ram_en,
  output logic          ram_we,
  output logic          ram_byte,
  output logic [AW-1:0] ram_addr,
  output logic [DW-1:0] ram_wdata,
  input  logic [DW-1:0] ram_rdata
);
  localparam int SW = $clog2(NSLOT);
  localparam int FSPAN = $clog2(NSLOT * 2);
  localparam int SP_SLOT = NSLOT - 1;

  logic [DW-1:0] fr [NSLOT];
  logic [DW-1:0] rd_q, loc_rd, slot_rd, mem_word;
  logic          ram_pend;

  wire in_port = cpu_addr[AW-1:2] == PORT_BASE[AW-1:2];
  wire in_fast = cpu_addr[AW-1:FSPAN] == FAST_BASE[AW-1:FSPAN];
  wire ram_sel = !in_port && !in_fast;
  wire odd     = cpu_addr[0];
  wire [SW-1:0] wslot = cpu_addr[SW:1];
  wire rd_req  = cpu_en && !cpu_we;
  wire mem_fast_we = cpu_en && cpu_we && in_fast;
  wire lcd_d_we = cpu_en && cpu_we && in_port && cpu_addr[1:0] == 2'd0;
  wire lcd_c_we = cpu_en && cpu_we && in_port && cpu_addr[1:0] == 2'd1;

  assign slot_rd = fr[wslot];

  always_comb begin
    if (cpu_byte)
      mem_word = odd ? {cpu_wdata[7:0], slot_rd[7:0]} : {slot_rd[15:8], cpu_wdata[7:0]};
    else
      mem_word = odd ? {cpu_wdata[7:0], cpu_wdata[15:8]} : cpu_wdata;
  end

  always_comb begin
    if (in_port)
      loc_rd = (cpu_addr[1:0] == 2'd2) ? {12'h0, dip_sw} : '0;
    else if (cpu_byte)
      loc_rd = {8'h0, odd ? slot_rd[15:8] : slot_rd[7:0]};
    else
      loc_rd = odd ? {slot_rd[7:0], slot_rd[15:8]} : slot_rd;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSLOT; i++) fr[i] <= '0;
      lcd_data <= '0;
      lcd_ctrl <= '0;
      rd_q     <= '0;
      ram_pend <= 1'b0;
    end else begin
      if (mem_fast_we) fr[wslot] <= mem_word;
      if (fx_we) fr[fx_idx] <= fx_wdata;
      if (sp_ld) fr[SP_SLOT] <= sp_ld_val;
      if (lcd_d_we) lcd_data <= cpu_wdata[7:0];
      if (lcd_c_we) lcd_ctrl <= cpu_wdata[7:0];
      rd_q     <= (rd_req && !ram_sel) ? loc_rd : '0;
      ram_pend <= rd_req && ram_sel;
    end
  end

  assign cpu_rdata = ram_pend ? ram_rdata : rd_q;
  assign fx_rdata  = fr[fx_idx];
  assign page_q    = fr[0];
  assign sp_q      = fr[SP_SLOT];

  assign ram_en    = cpu_en && ram_sel;
  assign ram_we    = ram_en && cpu_we;
  assign ram_byte  = cpu_byte;
  assign ram_addr  = cpu_addr;
  assign ram_wdata = cpu_wdata;

  assert_idle_rdata_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> cpu_rdata == '0);

  assert_lcd_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_d_we |=> lcd_data == $past(cpu_wdata[7:0]));

  assert_sw_write_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_en && cpu_we && in_port && cpu_addr[1] |=> $stable(lcd_data) && $stable(lcd_ctrl));

  assert_index_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fx_we && mem_fast_we && fx_idx == wslot && !(sp_ld && fx_idx == SW'(SP_SLOT))
    |=> fx_rdata == $past(fx_wdata) || fx_idx != $past(fx_idx));

  assert_sp_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sp_ld |=> sp_q == $past(sp_ld_val));

  assert_ram_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_en && (in_port || in_fast) |-> !ram_en && !ram_we);
endmodule

// File: tb/test_ioport_fastmem.sv
module test_ioport_fastmem;
  logic        clk = 0, rst_n = 0;
  logic        cpu_en = 0, cpu_we = 0, cpu_byte = 0;
  logic [31:0] cpu_addr = 0;
  logic [15:0] cpu_wdata = 0, fx_wdata = 0, sp_ld_val = 0, ram_rdata = 0;
  logic [3:0]  fx_idx = 0, dip_sw = 4'h9;
  logic        fx_we = 0, sp_ld = 0;
  logic [15:0] cpu_rdata, fx_rdata, sp_q, page_q, ram_wdata;
  logic [7:0]  lcd_data, lcd_ctrl;
  logic        ram_en, ram_we, ram_byte;
  logic [31:0] ram_addr;

  ioport_fastmem i_ioport_fastmem (.*);

  always #2 clk = ~clk;

  always @(posedge clk) if (ram_en && !ram_we) ram_rdata <= ram_addr[15:0] ^ 16'hA5A5;

  int n_chk = 0, n_fail = 0;
  logic [15:0] mfr [16];
  logic [7:0]  m_lcd_d = 0, m_lcd_c = 0;
  logic [15:0] m_rd = 0;
  string       m_rtag = "R1 idle rdata";

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_regs();
    chk("R2 R4 lcd_data", lcd_data, m_lcd_d);
    chk("R2 R4 lcd_ctrl", lcd_ctrl, m_lcd_c);
    chk("R9 page_q", page_q, mfr[0]);
    chk("R9 sp_q", sp_q, mfr[15]);
    chk(m_rtag, cpu_rdata, m_rd);
  endtask

  task automatic cyc(logic en, logic we, logic bs, logic [31:0] a, logic [15:0] wd,
                     logic fwe, logic [3:0] fi, logic [15:0] fwd, logic sl, logic [15:0] sv);
    logic inport, infast, isram, odd;
    logic [3:0] s;
    logic [15:0] w, nrd;
    logic [15:0] nfr [16];
    string ntag;
    cpu_en = en; cpu_we = we; cpu_byte = bs; cpu_addr = a; cpu_wdata = wd;
    fx_we = fwe; fx_idx = fi; fx_wdata = fwd; sp_ld = sl; sp_ld_val = sv;
    #1;
    inport = a[31:2] == 30'h3FFFC000;
    infast = a[31:5] == 27'h7FFF880;
    isram  = !inport && !infast;
    odd = a[0]; s = a[4:1]; w = mfr[s];
    chk("R8 fx_rdata", fx_rdata, mfr[fi]);
    chk("R10 ram_en", ram_en, en && isram);
    chk("R10 ram_we", ram_we, en && isram && we);
    if (en && isram) begin
      chk("R10 ram_addr", ram_addr, a);
      chk("R10 ram_wdata", ram_wdata, wd);
      chk("R10 ram_byte", ram_byte, bs);
    end
    nrd = 0; ntag = "R1 idle rdata";
    if (en && !we) begin
      if (isram) begin nrd = a[15:0] ^ 16'hA5A5; ntag = "R10 ram read"; end
      else if (inport) begin
        nrd = (a[1:0] == 2) ? {12'h0, dip_sw} : 16'h0;
        ntag = (a[1:0] == 2) ? "R3 switch read" : "R4 port read";
      end else if (bs) begin
        nrd = {8'h0, odd ? w[15:8] : w[7:0]}; ntag = "R7 byte read";
      end else begin
        nrd = odd ? {w[7:0], w[15:8]} : w; ntag = odd ? "R6 odd word read" : "R5 word read";
      end
    end
    foreach (nfr[i]) nfr[i] = mfr[i];
    if (en && we && infast) begin
      if (bs) nfr[s] = odd ? {wd[7:0], w[7:0]} : {w[15:8], wd[7:0]};
      else    nfr[s] = odd ? {wd[7:0], wd[15:8]} : wd;
    end
    if (fwe) nfr[fi] = fwd;
    if (sl) nfr[15] = sv;
    @(posedge clk);
    if (en && we && a == 32'hFFFF0000) m_lcd_d = wd[7:0];
    if (en && we && a == 32'hFFFF0001) m_lcd_c = wd[7:0];
    foreach (nfr[i]) mfr[i] = nfr[i];
    m_rd = nrd; m_rtag = ntag;
    @(negedge clk);
    check_regs();
  endtask

  task automatic mw(logic bs, logic [31:0] a, logic [15:0] d);
    cyc(1, 1, bs, a, d, 0, 0, 0, 0, 0);
  endtask
  task automatic mr(logic bs, logic [31:0] a);
    cyc(1, 0, bs, a, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    foreach (mfr[i]) mfr[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_regs();
    for (int i = 0; i < 16; i++) begin
      fx_idx = i[3:0]; #1; chk("R1 slot reset", fx_rdata, 16'h0);
    end
    // R2 LCD latches, both sizes
    mw(1, 32'hFFFF0000, 16'h1234);
    mw(0, 32'hFFFF0001, 16'hBEEF);
    // R4 reads of write-only ports and writes to read-only port
    mr(0, 32'hFFFF0000); mr(1, 32'hFFFF0001); mr(0, 32'hFFFF0003);
    mw(0, 32'hFFFF0002, 16'hFFFF); mw(1, 32'hFFFF0003, 16'h00AA);
    // R3 switch
    dip_sw = 4'hF; mr(0, 32'hFFFF0002);
    dip_sw = 4'h0; mr(1, 32'hFFFF0002);
    dip_sw = 4'h6; mr(0, 32'hFFFF0002);
    // R5 word access, page and stack slots by address
    mw(0, 32'hFFFF1000, 16'hA1B2); mw(0, 32'hFFFF101E, 16'h7FFE);
    mw(0, 32'hFFFF1008, 16'h1357); mr(0, 32'hFFFF1008);
    // R6 odd word access
    mr(0, 32'hFFFF1009); mw(0, 32'hFFFF100B, 16'hC0DE); mr(0, 32'hFFFF100A);
    // R7 byte lanes
    mw(1, 32'hFFFF1010, 16'hFF11); mw(1, 32'hFFFF1011, 16'h0022);
    mr(0, 32'hFFFF1010); mr(1, 32'hFFFF1011); mr(1, 32'hFFFF1010);
    // R8 index port and collision
    cyc(0, 0, 0, 0, 0, 1, 4'd3, 16'h3333, 0, 0);
    cyc(1, 1, 0, 32'hFFFF1006, 16'hDEAD, 1, 4'd3, 16'h4444, 0, 0);
    cyc(1, 0, 0, 32'hFFFF1006, 0, 1, 4'd5, 16'h5555, 0, 0);
    // R9 stack load beats both writers
    cyc(1, 1, 0, 32'hFFFF101E, 16'h1111, 1, 4'd15, 16'h2222, 1, 16'h3330);
    cyc(0, 0, 0, 0, 0, 0, 4'd15, 0, 1, 16'h0FF0);
    // R10 RAM pass-through, interleaved with local reads
    mr(0, 32'h00001234); mr(0, 32'hFFFF1000); mr(1, 32'h8000ABCD);
    mw(0, 32'h00000010, 16'h5A5A); mr(0, 32'hFFFF0FFE); mr(0, 32'hFFFF1020);
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] a;
      case ($urandom % 4)
        0: a = 32'hFFFF0000 | ($urandom % 4);
        1, 2: a = 32'hFFFF1000 | ($urandom % 32);
        default: a = {16'h1234, 16'($urandom)};
      endcase
      dip_sw = 4'($urandom);
      cyc(1'($urandom), 1'($urandom), 1'($urandom), a, 16'($urandom),
          ($urandom % 3) == 0, 4'($urandom), 16'($urandom), ($urandom % 8) == 0, 16'($urandom));
    end
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule